// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake

This block sits on a boot-time serial link and works out the host's baud rate before any real traffic flows. After reset it lets the line settle for a fixed number of cycles. It then times how long the receive line stays low while the host repeats the byte 0x00. In 8N1 framing that byte is low for nine bit times: the start bit and eight zero data bits. The block turns the shortest valid low period it sees into a clock divisor for a 16x oversampling bit clock.

Once the divisor is loaded, a small built-in transmitter sends a single 0x00 byte to tell the host that the rate is matched. A small built-in receiver then waits for one reply byte. A reply of 0x55 finishes the handshake. The block raises its done flag, drops both enables, parks the transmit line high and keeps the divisor on its output so later stages can reuse it. Any other reply, or a framing error, locks the block in an error state until the next reset.

Top module: `ab_boot_sync`

## Requirements
- R1: For SETTLE_CYC (default 100) cycles after reset the receive line is ignored. After that, a low period is timed only if the line has been seen high beforehand, so a low level already present when settling ends is never measured.
- R2: The divisor equals round(L / (9 × 16)), computed as (L + 72) / 144 and never less than 1. L is the measured low length in clock cycles.
- R3: L is the minimum over two consecutive valid low periods.
- R4: A low pulse shorter than MIN_LOW_CYC (default 32) cycles is a glitch. It is discarded and does not count as one of the two periods.
- R5: After measurement the block transmits exactly one byte, 0x00, in 8N1 (start bit 0, data LSB first, stop bit 1). Each bit lasts 16 × divisor cycles.
- R6: A received confirmation byte of 0x55 sets done_o. It clears rx_en_o and tx_en_o and keeps baud_div_o unchanged from then on.
- R7: txd_o is high whenever the transmitter is not sending, including after the handoff.
- R8: A confirmation byte other than 0x55 sets err_o. err_o stays set until reset, and done_o stays low.
- R9: A confirmation byte whose stop bit samples low sets err_o.
- R10: During reset txd_o = 1, and done_o, err_o, rx_en_o, tx_en_o and baud_div_o are all 0.
- R11: done_o and err_o are never both high, and each stays high once set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line from the host, idle high |
| txd_o | output | 1 | Serial line to the host, idle high |
| baud_div_o | output | CNT_W+1 | Clock cycles per oversampling tick |
| rx_en_o | output | 1 | Receive path active (measure, acknowledge, confirm phases) |
| tx_en_o | output | 1 | Transmit path active (acknowledge, confirm phases) |
| done_o | output | 1 | Handshake finished successfully |
| err_o | output | 1 | Handshake failed; cleared only by reset |

## Verification
The hardest case to reach from the ports is the line already being low when the settling interval ends. Only a correct arming rule keeps that partial pulse out of the minimum. The bench drives a 400-cycle low pulse that starts during settling and ends well after it, then checks that the divisor still reflects only the later zero bytes. Two further cases are reached by shaping host bytes at different bit lengths: a short glitch placed ahead of the zero bytes, and zero bytes of unequal length. The divisor and the acknowledge bit timing then show whether the glitch rule and the minimum rule were applied.

// File: rtl/ab_pkg.sv
package ab_pkg;

    localparam int AB_OVS       = 16;
    localparam int AB_LOW_BITS  = 9;
    localparam int AB_DEN       = AB_OVS * AB_LOW_BITS;
    localparam int AB_HALF      = AB_DEN / 2;
    localparam logic [7:0] AB_ACK_BYTE     = 8'h00;
    localparam logic [7:0] AB_CONFIRM_BYTE = 8'h55;

    typedef enum logic [2:0] {
        AB_SETTLE,
        AB_MEASURE,
        AB_ACK,
        AB_CONFIRM,
        AB_DONE,
        AB_FAIL
    } ab_state_t;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } ab_rx_state_t;

    typedef struct packed {
        logic       valid;
        logic       ferr;
        logic [7:0] data;
    } ab_rx_res_t;

endpackage

// File: rtl/ab_low_meter.sv
module ab_low_meter #(
    parameter int CNT_W       = 20,
    parameter int MIN_LOW_CYC = 32,
    parameter int N_MEAS      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             line,
    output logic             done,
    output logic [CNT_W-1:0] best
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int NV_W = $clog2(N_MEAS + 1);
    localparam logic [NV_W-1:0] NV_DONE = NV_W'(N_MEAS);

    logic             armed;
    logic             in_low;
    logic [CNT_W-1:0] cnt;
    logic [NV_W-1:0]  nvalid;
    logic             keep;

    assign keep = (cnt >= CNT_W'(MIN_LOW_CYC)) && (cnt != CNT_MAX);
    assign done = (nvalid == NV_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            in_low <= 1'b0;
            cnt    <= '0;
            nvalid <= '0;
            best   <= CNT_MAX;
        end else if (en && !done) begin
            if (!in_low) begin
                if (line) begin
                    armed <= 1'b1;
                end else if (armed) begin
                    in_low <= 1'b1;
                    cnt    <= CNT_W'(1);
                end
            end else if (!line) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else begin
                in_low <= 1'b0;
                if (keep) begin
                    nvalid <= nvalid + 1'b1;
                    if (cnt < best) best <= cnt;
                end
            end
        end
    end
endmodule

// File: rtl/ab_uart_tx.sv
module ab_uart_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       txd,
    output logic       done
);
    logic       busy;
    logic [9:0] shreg;
    logic [3:0] bitidx;
    logic [3:0] tcnt;

    assign txd = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            shreg  <= '1;
            bitidx <= '0;
            tcnt   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                shreg  <= {1'b1, data, 1'b0};
                bitidx <= '0;
                tcnt   <= '0;
            end else if (busy && tick) begin
                tcnt <= tcnt + 1'b1;
                if (tcnt == 4'd15) begin
                    shreg  <= {1'b1, shreg[9:1]};
                    bitidx <= bitidx + 1'b1;
                    if (bitidx == 4'd9) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ab_uart_rx.sv
module ab_uart_rx
    import ab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       line,
    output ab_rx_res_t res
);
    ab_rx_state_t st;
    logic [3:0]   tcnt;
    logic [2:0]   bitidx;
    logic [7:0]   shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st     <= RXS_IDLE;
            tcnt   <= '0;
            bitidx <= '0;
            shreg  <= '0;
            res    <= '0;
        end else begin
            res.valid <= 1'b0;
            res.ferr  <= 1'b0;
            if (tick) begin
                tcnt <= tcnt + 1'b1;
                unique case (st)
                    RXS_IDLE: begin
                        tcnt <= '0;
                        if (!line) st <= RXS_START;
                    end
                    RXS_START: begin
                        if (tcnt == 4'd7) begin
                            tcnt   <= '0;
                            bitidx <= '0;
                            st     <= line ? RXS_IDLE : RXS_DATA;
                        end
                    end
                    RXS_DATA: begin
                        if (tcnt == 4'd15) begin
                            shreg  <= {line, shreg[7:1]};
                            bitidx <= bitidx + 1'b1;
                            if (bitidx == 3'd7) st <= RXS_STOP;
                        end
                    end
                    RXS_STOP: begin
                        if (tcnt == 4'd15) begin
                            res.data  <= shreg;
                            res.valid <= line;
                            res.ferr  <= !line;
                            st        <= RXS_IDLE;
                        end
                    end
                    default: st <= RXS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ab_boot_sync.sv
module ab_boot_sync
    import ab_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SETTLE_CYC  = 100,
    parameter int MIN_LOW_CYC = 32,
    parameter int N_MEAS      = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rxd_i,
    output logic           txd_o,
    output logic [CNT_W:0] baud_div_o,
    output logic           rx_en_o,
    output logic           tx_en_o,
    output logic           done_o,
    output logic           err_o
);
    localparam int DIV_W = CNT_W + 1;
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC);

    ab_state_t        state;
    logic             rx_m, rx_s;
    logic [SET_W-1:0] set_cnt;
    logic             meas_done;
    logic [CNT_W-1:0] meas_best;
    logic [DIV_W-1:0] div_sum, div_quo, div_new, div_q;
    logic [DIV_W-1:0] tick_cnt;
    logic             tick;
    logic             run_clk;
    logic             tx_start, tx_done, tx_line;
    ab_rx_res_t       rx_res;

    // two-flop synchronizer on the host line, idle high
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd_i;
            rx_s <= rx_m;
        end
    end

    ab_low_meter #(
        .CNT_W(CNT_W), .MIN_LOW_CYC(MIN_LOW_CYC), .N_MEAS(N_MEAS)
    ) meter_i (
        .clk(clk), .rst(rst), .en(state == AB_MEASURE), .line(rx_s),
        .done(meas_done), .best(meas_best)
    );

    // rounded division by nine bit times of sixteen ticks each
    assign div_sum = {1'b0, meas_best} + DIV_W'(AB_HALF);
    assign div_quo = div_sum / DIV_W'(AB_DEN);
    assign div_new = (div_quo == '0) ? DIV_W'(1) : div_quo;

    // oversampling tick generator
    assign run_clk = (state == AB_ACK) || (state == AB_CONFIRM);
    assign tick    = run_clk && (tick_cnt == div_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run_clk) tick_cnt <= '0;
        else if (tick)       tick_cnt <= '0;
        else                 tick_cnt <= tick_cnt + 1'b1;
    end

    ab_uart_tx tx_i (
        .clk(clk), .rst(rst), .tick(tick), .start(tx_start),
        .data(AB_ACK_BYTE), .txd(tx_line), .done(tx_done)
    );

    ab_uart_rx rx_i (
        .clk(clk), .rst(rst), .en(state == AB_CONFIRM), .tick(tick),
        .line(rx_s), .res(rx_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= AB_SETTLE;
            set_cnt  <= '0;
            div_q    <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            unique case (state)
                AB_SETTLE: begin
                    set_cnt <= set_cnt + 1'b1;
                    if (set_cnt == SET_LAST - 1'b1) state <= AB_MEASURE;
                end
                AB_MEASURE: begin
                    if (meas_done) begin
                        div_q    <= div_new;
                        tx_start <= 1'b1;
                        state    <= AB_ACK;
                    end
                end
                AB_ACK: begin
                    if (tx_done) state <= AB_CONFIRM;
                end
                AB_CONFIRM: begin
                    if (rx_res.ferr) state <= AB_FAIL;
                    else if (rx_res.valid)
                        state <= (rx_res.data == AB_CONFIRM_BYTE) ? AB_DONE : AB_FAIL;
                end
                AB_DONE: state <= AB_DONE;
                AB_FAIL: state <= AB_FAIL;
                default: state <= AB_FAIL;
            endcase
        end
    end

    assign txd_o      = tx_line;
    assign baud_div_o = div_q;
    assign rx_en_o    = (state == AB_MEASURE) || run_clk;
    assign tx_en_o    = run_clk;
    assign done_o     = (state == AB_DONE);
    assign err_o      = (state == AB_FAIL);
endmodule

// File: rtl/ab_boot_sync_chk.sv
module ab_boot_sync_chk #(
    parameter int CNT_W = 20
) (
    input logic           clk,
    input logic           rst,
    input logic           txd_o,
    input logic [CNT_W:0] baud_div_o,
    input logic           rx_en_o,
    input logic           tx_en_o,
    input logic           done_o,
    input logic           err_o
);
    a_r11_done_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!rx_en_o && !tx_en_o));
    a_r6_div_held: assert property (@(posedge clk) disable iff (rst)
        done_o |=> $stable(baud_div_o));
    a_r7_txd_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_en_o |-> txd_o);
    a_r2_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        tx_en_o |-> (baud_div_o != '0));
endmodule

bind ab_boot_sync ab_boot_sync_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .txd_o(txd_o), .baud_div_o(baud_div_o),
    .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/ab_boot_sync_tb_top.sv
module ab_boot_sync_tb_top;
    localparam int CNT_W = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rxd = 1'b1;
    logic           txd;
    logic [CNT_W:0] div;
    logic           rx_en, tx_en, done, err;

    int n_vec  = 0;
    int n_bad  = 0;
    int mon_bit = 64;
    int mon_seen = 0;
    bit mon_busy = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    ab_boot_sync #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .rxd_i(rxd), .txd_o(txd), .baud_div_o(div),
        .rx_en_o(rx_en), .tx_en_o(tx_en), .done_o(done), .err_o(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int bitc, input logic stop_lvl);
        rxd = 1'b0; wait_cyc(bitc);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; wait_cyc(bitc);
        end
        rxd = stop_lvl; wait_cyc(bitc);
        rxd = 1'b1;
    endtask

    // monitor: decodes the transmit line and scores against the queue
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                mon_busy = 1;
                wait_cyc(mon_bit / 2);
                for (int i = 0; i < 8; i++) begin
                    wait_cyc(mon_bit);
                    got[i] = txd;
                end
                wait_cyc(mon_bit);
                check(txd === 1'b1, "R5 ack stop bit", int'(txd), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected extra byte", int'(got), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(got == e, "R5 ack byte value", int'(got), int'(e));
                end
                mon_seen++;
                mon_busy = 0;
            end
        end
    end

    task automatic do_reset;
        rst = 1'b1; rxd = 1'b1;
        wait_cyc(4);
        check(txd === 1'b1 && !done && !err && !rx_en && !tx_en && div == 0,
              "R10 reset state", int'({txd, done, err, rx_en, tx_en}), 16);
        rst = 1'b0;
        mon_seen = 0;
    endtask

    // full session: optional pre-settle pulse, optional glitch, two zero bytes
    task automatic session(input string tag, input bit pre, input bit glitch,
                           input int b1, input int b2, input int exp_div,
                           input logic [7:0] reply, input logic stop_lvl,
                           input bit exp_done);
        int hb;
        do_reset();
        if (pre) begin
            wait_cyc(10); rxd = 1'b0; wait_cyc(400); rxd = 1'b1; wait_cyc(50);
        end else begin
            wait_cyc(120);
        end
        if (glitch) begin
            rxd = 1'b0; wait_cyc(10); rxd = 1'b1; wait_cyc(100);
        end
        send_byte(8'h00, b1, 1'b1);
        wait_cyc(2 * b1);
        mon_bit = 16 * exp_div;
        exp_q.push_back(8'h00);
        send_byte(8'h00, b2, 1'b1);
        wait (exp_q.size() == 0 && !mon_busy);
        check(int'(div) == exp_div, {tag, " divisor"}, int'(div), exp_div);
        check(tx_en && rx_en && !done, {tag, " R5 enables during handshake"},
              int'({tx_en, rx_en, done}), 6);
        hb = 16 * exp_div;
        wait_cyc(2 * hb);
        send_byte(reply, hb, stop_lvl);
        wait_cyc(2 * hb);
        if (exp_done) begin
            check(done && !err, {tag, " R6 done after 0x55"}, int'({done, err}), 2);
            check(!rx_en && !tx_en, {tag, " R6 enables cleared"}, int'({rx_en, tx_en}), 0);
        end else begin
            check(err && !done, {tag, " R8/R9 error state"}, int'({err, done}), 2);
            check(!rx_en && !tx_en, {tag, " R8 enables cleared on error"},
                  int'({rx_en, tx_en}), 0);
        end
        wait_cyc(20 * hb);
        check(int'(div) == exp_div, {tag, " R6 divisor kept"}, int'(div), exp_div);
        check(txd === 1'b1, {tag, " R7 txd idle high"}, int'(txd), 1);
        check(mon_seen == 1, {tag, " R5 exactly one ack"}, mon_seen, 1);
        check(done == exp_done && err == !exp_done, {tag, " R11 outcome sticky"},
              int'({done, err}), exp_done ? 2 : 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R2: 64-cycle bits -> L=576 -> divisor 4
        session("R2 base", 0, 0, 64, 64, 4, 8'h55, 1'b1, 1);
        // R2 rounding: 70-cycle bits -> L=630 -> 4.375 rounds to 4
        session("R2 round down", 0, 0, 70, 70, 4, 8'h55, 1'b1, 1);
        // R2 rounding: 74-cycle bits -> L=666 -> 4.625 rounds to 5
        session("R2 round up", 0, 0, 74, 74, 5, 8'h55, 1'b1, 1);
        // R3: first low 648 (would give 5), second 576 -> minimum gives 4
        session("R3 minimum", 0, 0, 72, 64, 4, 8'h55, 1'b1, 1);
        // R4: 10-cycle glitch before the bytes is ignored
        session("R4 glitch", 0, 1, 80, 80, 5, 8'h55, 1'b1, 1);
        // R1: low pulse straddling the end of settling is not measured
        session("R1 settle", 1, 0, 64, 64, 4, 8'h55, 1'b1, 1);
        // R8: wrong confirmation byte
        session("R8 bad reply", 0, 0, 64, 64, 4, 8'hA5, 1'b1, 0);
        // R9: framing error on the confirmation byte
        session("R9 framing", 0, 0, 64, 64, 4, 8'h55, 1'b0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule